// File: doc/BRIEF.md
# Single-Cycle Processor Datapath

This block is the execution datapath of a single-cycle processor, offered without the control unit that would normally steer it. It holds a register bank with two combinational read ports and one clocked write port, an arithmetic-logic unit, and the multiplexers that choose the second ALU operand, the value written back and the memory address. Every select line, the ALU operation code, the three register addresses and the immediate value are inputs. The ALU status flags are outputs, so a controller or a testbench can sequence instructions one clock at a time.

Data memory sits outside the block. A store drives an address and write data on output ports. A load drives an address and takes the returned word on an input port in the same cycle, and that word is written into the destination register at the next rising edge. The memory output-enable is produced elsewhere and does not enter the datapath. Data width and register count are parameters. The default is 16-bit data, 16-bit addresses and 32 registers, with a 5-bit register address.

Top module: `dp_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared, so after reset every register reads back as zero.
- R2: A register takes the write-back value at a rising edge only when `wr_en` is 1 and `rd_addr` selects it. With `wr_en` at 0 nothing changes. A read of the destination before the edge still shows the old value, because there is no bypass.
- R3: Register 0 always reads as zero, and writes addressed to it are discarded.
- R4: With `b_sel` at 0 the second ALU operand is read port B. With `b_sel` at 1 it is `imm`.
- R5: `alu_op` encodings: 0 A+B, 1 A-B, 2 A+1, 3 A shifted left by B[log2(DW)-1:0], 4 A AND B, 5 A OR B, 6 A XOR B, 7 pass B.
- R6: `flag_z` is 1 when the ALU result is zero. `flag_n` is the result's top bit. `flag_c` is the carry out for add and increment, 1 for subtract when no borrow occurs, the last bit shifted out for shift-left (0 for a zero shift), and 0 for the logic and pass operations.
- R7: With `wb_sel` at 0 the written value is the ALU result. With `wb_sel` at 1 it is `mem_rdata`, sampled in the same cycle.
- R8: `mem_addr` is read port A when `addr_sel` is 0 and `imm` when it is 1. `mem_wdata` is always read port B.
- R9: The sequence increment R1 from R0, add 5 to R0 into R2, shift R1 left by 3 into R3, store R2 at address R3, then load R5 from address 0x1F1F leaves R1=1, R2=5 and R3=8. The store cycle drives address 8 and data 5 with no register written, and R5 ends at 7 when memory returns 7.
- R10: The two read ports are independent. Both may address the same register in the same cycle and both return its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the register bank |
| alu_op | input | 3 | ALU operation code |
| b_sel | input | 1 | Second operand select: 0 read port B, 1 immediate |
| wb_sel | input | 1 | Write-back select: 0 ALU result, 1 memory read data |
| addr_sel | input | 1 | Memory address select: 0 read port A, 1 immediate |
| wr_en | input | 1 | Register write enable |
| rd_addr | input | 5 | Destination register address |
| ra_addr | input | 5 | Read port A register address |
| rb_addr | input | 5 | Read port B register address |
| imm | input | 16 | Immediate value |
| mem_rdata | input | 16 | Data returned by external memory |
| mem_addr | output | 16 | Address to external memory |
| mem_wdata | output | 16 | Write data to external memory |
| flag_z | output | 1 | ALU zero flag |
| flag_n | output | 1 | ALU negative flag |
| flag_c | output | 1 | ALU carry flag |

## Verification
The bound checker watches, on every cycle, that read port B and register 0 on either port return zero, that a register held without a write keeps its value across an edge, that a load writes back exactly the memory word offered in its cycle, that the zero and negative flags agree with the value later read back from the destination, and that the bank is clear after reset. The per-operation results and carry values, the operand and address multiplexer choices, and the exact store and load addresses of the five-instruction program can only be shown by the bench's directed scenarios, which apply chosen operands and compare against fixed expected words.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_INC  = 3'd2,
    OP_SHL  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;
endpackage

// File: rtl/dp_regbank.sv
module dp_regbank #(
  parameter int DW   = 16,
  parameter int NREG = 32,
  parameter int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b
);
  // Entry 0 has no storage: it is hard-wired to zero (R3)
  logic [DW-1:0] regs_q [1:NREG-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i < NREG; i++) regs_q[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs_q[waddr] <= wdata;
    end
  end

  // Two independent combinational read ports (R10)
  assign rdata_a = (raddr_a == '0) ? '0 : regs_q[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs_q[raddr_b];
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int DW  = 16,
  parameter int SHW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zf,
  output logic          nf,
  output logic          cf
);
  localparam logic [DW:0] ONE = (DW+1)'(1);

  logic [DW:0] ext;
  alu_op_e     opc;

  assign opc = alu_op_e'(op);

  always_comb begin
    unique case (opc)
      OP_ADD:  ext = {1'b0, a} + {1'b0, b};
      OP_SUB:  ext = {1'b0, a} + {1'b0, ~b} + ONE;
      OP_INC:  ext = {1'b0, a} + ONE;
      OP_SHL:  ext = {1'b0, a} << b[SHW-1:0];
      OP_AND:  ext = {1'b0, a & b};
      OP_OR:   ext = {1'b0, a | b};
      OP_XOR:  ext = {1'b0, a ^ b};
      default: ext = {1'b0, b};
    endcase
  end

  assign y  = ext[DW-1:0];
  assign cf = ext[DW];
  assign zf = (y == '0);
  assign nf = y[DW-1];
endmodule

// File: rtl/dp_datapath.sv
module dp_datapath #(
  parameter int DW   = 16,
  parameter int NREG = 32,
  parameter int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     alu_op,
  input  logic           b_sel,
  input  logic           wb_sel,
  input  logic           addr_sel,
  input  logic           wr_en,
  input  logic [RAW-1:0] rd_addr,
  input  logic [RAW-1:0] ra_addr,
  input  logic [RAW-1:0] rb_addr,
  input  logic [DW-1:0]  imm,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic           flag_z,
  output logic           flag_n,
  output logic           flag_c
);
  logic [DW-1:0] port_a, port_b, opnd_b, alu_y, wb_data;

  dp_regbank #(.DW(DW), .NREG(NREG), .RAW(RAW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (rd_addr),
    .wdata   (wb_data),
    .raddr_a (ra_addr),
    .raddr_b (rb_addr),
    .rdata_a (port_a),
    .rdata_b (port_b)
  );

  // Second operand: register or immediate (R4)
  assign opnd_b = b_sel ? imm : port_b;

  dp_alu #(.DW(DW)) u_alu (
    .op (alu_op),
    .a  (port_a),
    .b  (opnd_b),
    .y  (alu_y),
    .zf (flag_z),
    .nf (flag_n),
    .cf (flag_c)
  );

  // Write-back: ALU result or memory word (R7)
  assign wb_data = wb_sel ? mem_rdata : alu_y;

  // Memory side: register-indirect or absolute address (R8)
  assign mem_addr  = addr_sel ? imm : port_a;
  assign mem_wdata = port_b;
endmodule

// File: rtl/dp_datapath_chk.sv
module dp_datapath_chk #(
  parameter int DW  = 16,
  parameter int RAW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           wb_sel,
  input logic           addr_sel,
  input logic           wr_en,
  input logic [RAW-1:0] rd_addr,
  input logic [RAW-1:0] ra_addr,
  input logic [RAW-1:0] rb_addr,
  input logic [DW-1:0]  mem_rdata,
  input logic [DW-1:0]  mem_addr,
  input logic [DW-1:0]  mem_wdata,
  input logic           flag_z,
  input logic           flag_n
);
  a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_wdata == '0));

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || (rd_addr != rb_addr)) ##1 (rb_addr == $past(rb_addr))
      |-> (mem_wdata == $past(mem_wdata)));

  a_r3_zero_port_b: assert property (@(posedge clk) disable iff (rst)
    (rb_addr == '0) |-> (mem_wdata == '0));

  a_r3_zero_port_a: assert property (@(posedge clk) disable iff (rst)
    (!addr_sel && (ra_addr == '0)) |-> (mem_addr == '0));

  a_r7_load_writeback: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wb_sel && (rd_addr != '0)) ##1 (rb_addr == $past(rd_addr))
      |-> (mem_wdata == $past(mem_rdata)));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wb_sel && (rd_addr != '0) && flag_z) ##1 (rb_addr == $past(rd_addr))
      |-> (mem_wdata == '0));

  a_r6_neg_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wb_sel && (rd_addr != '0) && flag_n) ##1 (rb_addr == $past(rd_addr))
      |-> mem_wdata[DW-1]);
endmodule

bind dp_datapath dp_datapath_chk #(.DW(DW), .RAW(RAW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wb_sel    (wb_sel),
  .addr_sel  (addr_sel),
  .wr_en     (wr_en),
  .rd_addr   (rd_addr),
  .ra_addr   (ra_addr),
  .rb_addr   (rb_addr),
  .mem_rdata (mem_rdata),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .flag_z    (flag_z),
  .flag_n    (flag_n)
);

// File: tb/sim_dp_datapath.sv
module sim_dp_datapath;
  localparam int DW   = 16;
  localparam int NREG = 32;
  localparam int RAW  = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [2:0]     alu_op = '0;
  logic           b_sel = 1'b0, wb_sel = 1'b0, addr_sel = 1'b0, wr_en = 1'b0;
  logic [RAW-1:0] rd_addr = '0, ra_addr = '0, rb_addr = '0;
  logic [DW-1:0]  imm = '0, mem_rdata = '0;
  logic [DW-1:0]  mem_addr, mem_wdata;
  logic           flag_z, flag_n, flag_c;

  int checks = 0;
  int errors = 0;

  dp_datapath #(.DW(DW), .NREG(NREG), .RAW(RAW)) u0 (
    .clk(clk), .rst(rst), .alu_op(alu_op), .b_sel(b_sel), .wb_sel(wb_sel),
    .addr_sel(addr_sel), .wr_en(wr_en), .rd_addr(rd_addr), .ra_addr(ra_addr),
    .rb_addr(rb_addr), .imm(imm), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input int ra, input int rb, input int rd,
                       input logic [DW-1:0] iv, input logic bs, input logic ws,
                       input logic as, input logic we, input logic [DW-1:0] md);
    alu_op = op; ra_addr = RAW'(ra); rb_addr = RAW'(rb); rd_addr = RAW'(rd);
    imm = iv; b_sel = bs; wb_sel = ws; addr_sel = as; wr_en = we; mem_rdata = md;
    #1;
  endtask

  task automatic commit;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input int idx, output logic [DW-1:0] v);
    wr_en = 1'b0; rb_addr = RAW'(idx);
    #1;
    v = mem_wdata;
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      read_reg(i, v);
      check($sformatf("R1 reg %0d cleared", i), 32'(v), 32'h0);
    end
  endtask

  task automatic t_program;
    logic [DW-1:0] v;
    drive(3'd2, 0, 0, 1, 16'h0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0); // inc R1,R0
    commit;
    drive(3'd0, 0, 0, 2, 16'h5, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0); // addi R2,R0,5
    commit;
    drive(3'd3, 1, 0, 3, 16'h3, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0); // shl R3,R1,3
    commit;
    read_reg(1, v); check("R9 R1 after inc", 32'(v), 32'h1);
    read_reg(2, v); check("R9 R2 after addi", 32'(v), 32'h5);
    read_reg(3, v); check("R9 R3 after shl", 32'(v), 32'h8);
    drive(3'd0, 3, 2, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0); // store R2 at [R3]
    check("R8 R9 store address", 32'(mem_addr), 32'h8);
    check("R8 R9 store data", 32'(mem_wdata), 32'h5);
    commit;
    read_reg(3, v); check("R9 R3 unchanged by store", 32'(v), 32'h8);
    drive(3'd0, 0, 0, 5, 16'h1F1F, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0007); // load R5
    check("R8 R9 load address", 32'(mem_addr), 32'h1F1F);
    commit;
    mem_rdata = '0;
    read_reg(5, v); check("R7 R9 R5 loaded", 32'(v), 32'h7);
  endtask

  task automatic t_zero_reg;
    logic [DW-1:0] v;
    drive(3'd7, 0, 0, 0, 16'h1234, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
    commit;
    read_reg(0, v); check("R3 R0 write ignored (port B)", 32'(v), 32'h0);
    drive(3'd0, 0, 0, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    check("R3 R0 reads zero (port A)", 32'(mem_addr), 32'h0);
  endtask

  task automatic t_no_write;
    logic [DW-1:0] v;
    drive(3'd7, 0, 4, 4, 16'hABCD, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
    commit;
    read_reg(4, v); check("R2 no write when wr_en low", 32'(v), 32'h0);
    drive(3'd7, 0, 4, 4, 16'h4444, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
    check("R2 no bypass before edge", 32'(mem_wdata), 32'h0);
    commit;
    read_reg(4, v); check("R2 written at edge", 32'(v), 32'h4444);
  endtask

  task automatic alu_case(input string name, input logic [2:0] op, input logic [DW-1:0] b,
                          input logic [DW-1:0] ey, input logic ec, input logic en, input logic ez);
    logic [DW-1:0] v;
    drive(op, 6, 0, 7, b, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
    check({"R6 carry ", name}, 32'(flag_c), 32'(ec));
    check({"R6 negative ", name}, 32'(flag_n), 32'(en));
    check({"R6 zero ", name}, 32'(flag_z), 32'(ez));
    commit;
    read_reg(7, v);
    check({"R5 result ", name}, 32'(v), 32'(ey));
  endtask

  task automatic t_alu;
    drive(3'd0, 0, 0, 6, 16'h8001, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
    commit;
    alu_case("add",  3'd0, 16'h8003, 16'h0004, 1'b1, 1'b0, 1'b0);
    alu_case("sub",  3'd1, 16'h8003, 16'hFFFE, 1'b0, 1'b1, 1'b0);
    alu_case("inc",  3'd2, 16'h0000, 16'h8002, 1'b0, 1'b1, 1'b0);
    alu_case("shl1", 3'd3, 16'h0001, 16'h0002, 1'b1, 1'b0, 1'b0);
    alu_case("shl0", 3'd3, 16'h0000, 16'h8001, 1'b0, 1'b1, 1'b0);
    alu_case("and",  3'd4, 16'h8003, 16'h8001, 1'b0, 1'b1, 1'b0);
    alu_case("or",   3'd5, 16'h00F0, 16'h80F1, 1'b0, 1'b1, 1'b0);
    alu_case("xor",  3'd6, 16'h8001, 16'h0000, 1'b0, 1'b0, 1'b1);
    alu_case("pass", 3'd7, 16'h7FFF, 16'h7FFF, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bsel;
    logic [DW-1:0] v;
    drive(3'd0, 1, 2, 8, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0);
    commit;
    read_reg(8, v); check("R4 operand from port B", 32'(v), 32'h6);
    drive(3'd0, 1, 2, 8, 16'h0100, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0);
    commit;
    read_reg(8, v); check("R4 operand from immediate", 32'(v), 32'h0101);
  endtask

  task automatic t_dual_read;
    drive(3'd0, 5, 5, 0, 16'h0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0);
    check("R10 port A same register", 32'(mem_addr), 32'h7);
    check("R10 port B same register", 32'(mem_wdata), 32'h7);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset;
    t_program;
    t_zero_reg;
    t_no_write;
    t_alu;
    t_bsel;
    t_dual_read;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule